// File: doc/BRIEF.md
# Tagged ADC Sample FIFO with Threshold and Overrun Events

This block is a single-clock first-in first-out buffer that holds converted analog samples on their way from the converters to the host-side data mover. Each entry carries the 16-bit conversion result, a 3-bit input number and a converter-select bit. The converter-select bit lifts the input number into the upper half of a 0 to 15 range, so a consumer can name the source input of any sample without further decoding.

The host watches an occupancy count and programs an almost-full threshold. When a write raises the count to that threshold, the block emits a single-cycle almost-full event. When a sample arrives with no free entry, the sample is discarded and a single-cycle overrun event is raised. Reads return data one cycle after the request, in write order. The storage depth is a power of two set by a parameter. The target size is 32768 entries, and smaller values serve simulation.

Top module: `adc_sample_fifo`

## Requirements
- R1: After reset the FIFO is empty: `level` is 0, `empty` is 1, `full`, `af_pulse` and `ovr_pulse` are 0, and the read outputs are all zero.
- R2: Samples leave in the order they were written. The sample fetched by an accepted read appears on the read outputs in the cycle after the read edge, and it stays there until the next accepted read.
- R3: `level` rises by one for each accepted write and falls by one for each accepted read. `empty` is 1 exactly when `level` is 0, and `full` is 1 exactly when `level` equals 2**AW.
- R4: A write presented while `full` is 1 is discarded. The stored samples and their order are unchanged, and `level` does not rise.
- R5: `ovr_pulse` is 1 for one cycle, in the cycle after any edge at which `wr_en` was 1 while `full` was 1, and it is 0 at all other times.
- R6: `af_pulse` is 1 for one cycle after an edge at which `level` rose from `af_thresh`-1 to `af_thresh`. It stays 0 when `level` reaches that value by falling, while `level` stays at that value, and always when `af_thresh` is 0.
- R7: When `rd_en` and `wr_en` are both 1 while the FIFO is neither empty nor full, both operations take effect and `level` stays the same.
- R8: A read presented while `empty` is 1 is ignored. The read outputs keep their previous values and `level` stays at 0.
- R9: `rd_src` equals `rd_adc_hi` times 8 plus `rd_chan`: bit 3 is the converter-select bit and bits 2:0 are the input number.
- R10: A write and a read presented together while `empty` is 1 store the sample, ignore the read and leave `level` at 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write request |
| wr_count | input | DW | Conversion result to store |
| wr_chan | input | CW | Input number of the sample |
| wr_adc_hi | input | 1 | Converter-select bit of the sample |
| rd_en | input | 1 | Read request |
| rd_count | output | DW | Conversion result of the last read |
| rd_chan | output | CW | Input number of the last read |
| rd_adc_hi | output | 1 | Converter-select bit of the last read |
| rd_src | output | CW+1 | Effective source input, 0 to 15 |
| level | output | AW+1 | Occupancy count |
| af_thresh | input | AW+1 | Almost-full threshold |
| af_pulse | output | 1 | One-cycle almost-full event |
| ovr_pulse | output | 1 | One-cycle overrun event |
| empty | output | 1 | No stored samples |
| full | output | 1 | All entries occupied |

## Verification
The assertions check on every cycle that the count stays within bounds and changes by at most one. They also check that a write at full leaves the count unchanged and raises the overrun event, and that every almost-full event follows a one-step rise onto the threshold. They cover the held count during a combined read and write, the frozen outputs during a read from empty, and a combined access on an empty FIFO. Only the bench scenarios show that data leaves in write order with the correct tags, that a discarded write leaves the stored contents intact, and that the threshold event repeats each time the count climbs back to the threshold.

// File: rtl/adc_sample_fifo.sv
module adc_sample_fifo #(
  parameter int AW = 6,
  parameter int DW = 16,
  parameter int CW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [DW-1:0] wr_count,
  input  logic [CW-1:0] wr_chan,
  input  logic          wr_adc_hi,
  input  logic          rd_en,
  output logic [DW-1:0] rd_count,
  output logic [CW-1:0] rd_chan,
  output logic          rd_adc_hi,
  output logic [CW:0]   rd_src,
  output logic [AW:0]   level,
  input  logic [AW:0]   af_thresh,
  output logic          af_pulse,
  output logic          ovr_pulse,
  output logic          empty,
  output logic          full
);
  localparam int DEPTH = 1 << AW;
  localparam int EW = DW + CW + 1;
  localparam logic [AW:0] FULL_LVL = (AW+1)'(DEPTH);
  localparam logic [AW:0] ONE = (AW+1)'(1);

  logic [EW-1:0] mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic          wr_ok, rd_ok;

  assign empty  = (level == '0);
  assign full   = (level == FULL_LVL);
  assign wr_ok  = wr_en && !full;
  assign rd_ok  = rd_en && !empty;
  assign rd_src = {rd_adc_hi, rd_chan};

  always_ff @(posedge clk)
    if (wr_ok) mem[wp] <= {wr_adc_hi, wr_chan, wr_count};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wp        <= '0;
      rp        <= '0;
      level     <= '0;
      rd_count  <= '0;
      rd_chan   <= '0;
      rd_adc_hi <= 1'b0;
      af_pulse  <= 1'b0;
      ovr_pulse <= 1'b0;
    end else begin
      if (wr_ok) wp <= wp + 1'b1;
      if (rd_ok) begin
        rp <= rp + 1'b1;
        {rd_adc_hi, rd_chan, rd_count} <= mem[rp];
      end
      case ({wr_ok, rd_ok})
        2'b10:   level <= level + ONE;
        2'b01:   level <= level - ONE;
        default: level <= level;
      endcase
      af_pulse  <= wr_ok && !rd_ok && (level + ONE == af_thresh);
      ovr_pulse <= wr_en && full;
    end
  end
endmodule

module adc_sample_fifo_chk #(
  parameter int AW = 6,
  parameter int DW = 16,
  parameter int CW = 3
) (
  input logic          clk,
  input logic          rst_n,
  input logic          wr_en,
  input logic          rd_en,
  input logic [DW-1:0] rd_count,
  input logic [AW:0]   level,
  input logic [AW:0]   af_thresh,
  input logic          af_pulse,
  input logic          ovr_pulse,
  input logic          empty,
  input logic          full
);
  localparam logic [AW:0] FULL_LVL = (AW+1)'(1 << AW);
  localparam logic [AW:0] ONE = (AW+1)'(1);

  p_level_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
    level <= FULL_LVL);
  p_level_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (level == $past(level) || level == $past(level) + ONE || level == $past(level) - ONE));
  p_drop_when_full_r4: assert property (@(posedge clk) disable iff (!rst_n)
    full && wr_en && !rd_en |=> $stable(level));
  p_overrun_r5: assert property (@(posedge clk) disable iff (!rst_n)
    full && wr_en |=> ovr_pulse);
  p_overrun_cause_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ovr_pulse |-> $past(full && wr_en));
  p_af_rise_r6: assert property (@(posedge clk) disable iff (!rst_n)
    af_pulse |-> (level == $past(af_thresh) && level == $past(level) + ONE));
  p_simul_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !empty && !full && rd_en && wr_en |=> $stable(level));
  p_empty_read_r8: assert property (@(posedge clk) disable iff (!rst_n)
    empty && rd_en && !wr_en |=> $stable(rd_count) && $stable(level));
  p_empty_both_r10: assert property (@(posedge clk) disable iff (!rst_n)
    empty && rd_en && wr_en |=> level == ONE);
endmodule

bind adc_sample_fifo adc_sample_fifo_chk #(.AW(AW), .DW(DW), .CW(CW)) u_chk (.*);

// File: tb/adc_sample_fifo_test.sv
module adc_sample_fifo_test;
  localparam int AW = 3;
  localparam int DEPTH = 1 << AW;

  logic clk = 0, rst_n = 0;
  logic wr_en = 0, wr_adc_hi = 0, rd_en = 0;
  logic [15:0] wr_count = 0;
  logic [2:0] wr_chan = 0;
  logic [AW:0] af_thresh = 0;
  logic [15:0] rd_count;
  logic [2:0] rd_chan;
  logic rd_adc_hi, af_pulse, ovr_pulse, empty, full;
  logic [3:0] rd_src;
  logic [AW:0] level;

  always #10 clk = ~clk;

  adc_sample_fifo #(.AW(AW)) uut (.*);

  int errors = 0, checks = 0;
  bit done = 0;
  logic [19:0] q[$];
  logic [19:0] m_rd = '0;
  logic m_af = 0, m_ovr = 0;

  task automatic chk(input string rq, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", rq, what, act, exp);
    end
  endtask

  task automatic compare(input string rq);
    chk(rq, "level", int'(level), q.size());
    chk(rq, "empty", int'(empty), int'(q.size() == 0));
    chk(rq, "full", int'(full), int'(q.size() == DEPTH));
    chk(rq, "rd_count", int'(rd_count), int'(m_rd[15:0]));
    chk(rq, "rd_chan", int'(rd_chan), int'(m_rd[18:16]));
    chk(rq, "rd_adc_hi", int'(rd_adc_hi), int'(m_rd[19]));
    chk({rq, "/R9"}, "rd_src", int'(rd_src), int'(m_rd[19]) * 8 + int'(m_rd[18:16]));
    chk(rq, "af_pulse", int'(af_pulse), int'(m_af));
    chk(rq, "ovr_pulse", int'(ovr_pulse), int'(m_ovr));
  endtask

  task automatic cyc(input logic w, input logic [15:0] d, input logic [2:0] c,
                     input logic h, input logic r, input string rq);
    int n0;
    logic wok, rok;
    wr_en = w; wr_count = d; wr_chan = c; wr_adc_hi = h; rd_en = r;
    @(posedge clk);
    n0 = q.size();
    wok = w && (n0 != DEPTH);
    rok = r && (n0 != 0);
    if (rok) m_rd = q.pop_front();
    if (wok) q.push_back({h, c, d});
    m_ovr = w && (n0 == DEPTH);
    m_af = wok && !rok && (n0 + 1 == int'(af_thresh));
    @(negedge clk);
    compare(rq);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    compare("R1");
    cyc(1, 16'h1234, 3'd5, 1'b1, 0, "R2");
    cyc(1, 16'hABCD, 3'd2, 1'b0, 0, "R2");
    cyc(1, 16'h00FF, 3'd7, 1'b1, 0, "R3");
    for (int i = 0; i < 3; i++) cyc(0, 0, 0, 0, 1, "R2");
    cyc(0, 0, 0, 0, 1, "R8");
    cyc(0, 0, 0, 0, 1, "R8");
    cyc(1, 16'h5555, 3'd1, 1'b1, 1, "R10");
    cyc(0, 0, 0, 0, 1, "R2");
    af_thresh = 5;
    for (int i = 0; i < DEPTH; i++) cyc(1, 16'(16'h100 + i), 3'(i), i[0], 0, "R6");
    cyc(1, 16'hDEAD, 3'd3, 1'b1, 0, "R5");
    cyc(1, 16'hBEEF, 3'd4, 1'b0, 0, "R4");
    cyc(1, 16'hCAFE, 3'd6, 1'b1, 1, "R5");
    cyc(1, 16'h0777, 3'd0, 1'b0, 0, "R3");
    for (int i = 0; i < 4; i++) cyc(1, 16'(16'h200 + i), 3'(i), 1'b1, 1, "R7");
    for (int i = 0; i < 4; i++) cyc(0, 0, 0, 0, 1, "R4");
    cyc(1, 16'h0300, 3'd1, 1'b0, 1, "R7");
    cyc(0, 0, 0, 0, 1, "R6");
    cyc(1, 16'h0301, 3'd2, 1'b1, 0, "R6");
    while (q.size() != 0) cyc(0, 0, 0, 0, 1, "R2");
    af_thresh = 0;
    for (int i = 0; i < DEPTH; i++) cyc(1, 16'(i * 3), 3'(i), 1'b0, 0, "R6");
    while (q.size() != 0) cyc(0, 0, 0, 0, 1, "R3");
    af_thresh = 3;
    for (int i = 0; i < 600; i++)
      cyc(1'($urandom_range(0, 99) < 55), 16'($urandom), 3'($urandom), 1'($urandom),
          1'($urandom_range(0, 99) < 45), "R3");
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule